// File: doc/BRIEF.md
# Serial Port Interrupt Enable and Status Unit

This block collects the interrupt causes of one serial port and turns them into a single level interrupt for the processor. Receive-data, transmit-data and receive-timeout event pulses set sticky flags in a status word. Six line and transmitter events (overrun, CTS change, receive break, transmit ready, all-sent, break end) set sticky bits in a separate change word, and those bits fold into one summary bit. A control word holds the enables: per-class interrupt enables, the six change-source enables and two DMA enable bits that are only stored and read back.

Software reaches the three words over a small register bus. A write of 0 to a sticky bit clears it, and a write of 1 leaves it alone, so one handler can acknowledge exactly the causes it has serviced. The receiver's level signals (break, FIFO empty, framing, parity, overrun, fill count) appear in the status word as they are.

Top module: `sio_irq_unit`

## Requirements
- R1: After reset the control word, the three sticky status flags and the change word are all 0, and irq_o is low.
- R2: Address 0 is the control word. A write stores bits 15:11 and 5:0; bits 10:6 always read 0. Bit 13 is the transmit enable, bit 12 the receive enable, bit 11 the summary enable, bits 5:0 the change-source enables.
- R3: Address 1 reads the status word: bit 15 break, 14 receive FIFO empty, 13 framing error, 12 parity error, 11 overrun (all live inputs), bit 10 the OR of break, framing, parity and overrun, bit 5 reads 0 and bits 4:0 the receive fill count.
- R4: A pulse on rx_data_evt_i, tx_data_evt_i or rx_tout_evt_i sets status bit 7, 8 or 9 respectively, and the bit stays set after the pulse ends.
- R5: A write to address 1 clears each of bits 9:7 whose written value is 0 and leaves each whose written value is 1 unchanged; all other status bits ignore the write.
- R6: When a set pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R7: Address 2 reads the change word in bits 5:0 (bits 15:6 read 0); chg_evt_i bit n sets bit n, and a write to address 2 clears bits written 0 and keeps bits written 1.
- R8: Status bit 6 is 1 exactly when some change-word bit is 1 and the control enable at the same position is 1.
- R9: irq_o is high exactly when (receive flag or timeout flag) with receive enable, or transmit flag with transmit enable, or summary bit with summary enable.
- R10: With transmit enable clear, a set transmit flag stays readable in status bit 8 but does not raise irq_o.
- R11: With the control word written to 0, irq_o is low whatever flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 change |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| rx_data_evt_i | input | 1 | Receive data event pulse |
| tx_data_evt_i | input | 1 | Transmit data event pulse |
| rx_tout_evt_i | input | 1 | Receive timeout event pulse |
| chg_evt_i | input | 6 | Change event pulses, bit order as change word |
| rx_brk_i | input | 1 | Break detected level |
| rx_empty_i | input | 1 | Receive FIFO empty level |
| rx_ferr_i | input | 1 | Framing error level |
| rx_perr_i | input | 1 | Parity error level |
| rx_ovr_i | input | 1 | Overrun level |
| rx_level_i | input | 5 | Receive FIFO fill count |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench goes after the same-cycle collision of a set pulse and a clearing write; a design that lets the clear win would lose an event and the handler would never see it. It checks that a written 1 preserves a flag, since a design that stores the written value would wrongly clear or set flags. It checks the transmit flag with its enable clear and an all-zero control word, where a design that leaves the transmit or timeout path ungated would raise a spurious interrupt, and the summary bit against the per-source enables, where a wrong mask bit position would hide or invent a change interrupt.

// File: rtl/sio_irq_pkg.sv
`timescale 1ns/1ps
package sio_irq_pkg;
  localparam int unsigned REG_W = 16;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CHG  = 2'd2
  } reg_addr_e;

  // control word
  localparam int unsigned CB_TDMA = 15;
  localparam int unsigned CB_RDMA = 14;
  localparam int unsigned CB_TIE  = 13;
  localparam int unsigned CB_RIE  = 12;
  localparam int unsigned CB_SPIE = 11;
  localparam logic [REG_W-1:0] CTRL_WMASK = 16'hF83F;

  // status word
  localparam int unsigned SB_BRK   = 15;
  localparam int unsigned SB_EMPTY = 14;
  localparam int unsigned SB_FER   = 13;
  localparam int unsigned SB_PER   = 12;
  localparam int unsigned SB_OER   = 11;
  localparam int unsigned SB_ERR   = 10;
  localparam int unsigned SB_TOUT  = 9;
  localparam int unsigned SB_TX    = 8;
  localparam int unsigned SB_RX    = 7;
  localparam int unsigned SB_SUM   = 6;

  // sticky flag bank index
  localparam int unsigned FL_RX   = 0;
  localparam int unsigned FL_TX   = 1;
  localparam int unsigned FL_TOUT = 2;
  localparam int unsigned FL_N    = 3;
endpackage

// File: rtl/sio_flag_bank.sv
`timescale 1ns/1ps
module sio_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(q_o));
endmodule

// File: rtl/sio_ctrl_reg.sv
`timescale 1ns/1ps
module sio_ctrl_reg #(
  parameter int unsigned         W     = 16,
  parameter logic [W-1:0]        WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i & WMASK;
  end

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i & WMASK)));
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/sio_irq_combine.sv
`timescale 1ns/1ps
module sio_irq_combine #(
  parameter int unsigned NUM_CHG = 6
) (
  input  logic               rx_f_i,
  input  logic               tx_f_i,
  input  logic               tout_f_i,
  input  logic [NUM_CHG-1:0] chg_i,
  input  logic [NUM_CHG-1:0] chg_en_i,
  input  logic               rie_i,
  input  logic               tie_i,
  input  logic               spie_i,
  output logic               sum_o,
  output logic               irq_o
);
  assign sum_o = |(chg_i & chg_en_i);
  // timeout is a receive-side cause, gated with the receive enable
  assign irq_o = ((rx_f_i | tout_f_i) & rie_i) | (tx_f_i & tie_i) | (sum_o & spie_i);
endmodule

// File: rtl/sio_irq_unit.sv
`timescale 1ns/1ps
module sio_irq_unit
  import sio_irq_pkg::*;
#(
  parameter int unsigned NUM_CHG = 6,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               rx_data_evt_i,
  input  logic               tx_data_evt_i,
  input  logic               rx_tout_evt_i,
  input  logic [NUM_CHG-1:0] chg_evt_i,
  input  logic               rx_brk_i,
  input  logic               rx_empty_i,
  input  logic               rx_ferr_i,
  input  logic               rx_perr_i,
  input  logic               rx_ovr_i,
  input  logic [CNT_W-1:0]   rx_level_i,
  output logic               irq_o
);
  logic [REG_W-1:0]   ctrl_q;
  logic [FL_N-1:0]    fl_set, fl_clr, fl_q;
  logic [NUM_CHG-1:0] chg_clr, chg_q;
  logic               ctrl_we, stat_we, chg_we, sum;
  logic [REG_W-1:0]   stat_w;

  assign ctrl_we = wr_en_i && (addr_i == ADDR_CTRL);
  assign stat_we = wr_en_i && (addr_i == ADDR_STAT);
  assign chg_we  = wr_en_i && (addr_i == ADDR_CHG);

  sio_ctrl_reg #(.W(REG_W), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we), .wdata_i, .q_o(ctrl_q)
  );

  always_comb begin
    fl_set          = '0;
    fl_set[FL_RX]   = rx_data_evt_i;
    fl_set[FL_TX]   = tx_data_evt_i;
    fl_set[FL_TOUT] = rx_tout_evt_i;
    fl_clr          = '0;
    fl_clr[FL_RX]   = stat_we && !wdata_i[SB_RX];
    fl_clr[FL_TX]   = stat_we && !wdata_i[SB_TX];
    fl_clr[FL_TOUT] = stat_we && !wdata_i[SB_TOUT];
  end

  sio_flag_bank #(.N(FL_N)) u_flags (
    .clk_i, .rst_ni, .set_i(fl_set), .clr_i(fl_clr), .q_o(fl_q)
  );

  assign chg_clr = chg_we ? ~wdata_i[NUM_CHG-1:0] : '0;

  sio_flag_bank #(.N(NUM_CHG)) u_chg (
    .clk_i, .rst_ni, .set_i(chg_evt_i), .clr_i(chg_clr), .q_o(chg_q)
  );

  sio_irq_combine #(.NUM_CHG(NUM_CHG)) u_comb (
    .rx_f_i(fl_q[FL_RX]), .tx_f_i(fl_q[FL_TX]), .tout_f_i(fl_q[FL_TOUT]),
    .chg_i(chg_q), .chg_en_i(ctrl_q[NUM_CHG-1:0]),
    .rie_i(ctrl_q[CB_RIE]), .tie_i(ctrl_q[CB_TIE]), .spie_i(ctrl_q[CB_SPIE]),
    .sum_o(sum), .irq_o
  );

  always_comb begin
    stat_w            = '0;
    stat_w[SB_BRK]    = rx_brk_i;
    stat_w[SB_EMPTY]  = rx_empty_i;
    stat_w[SB_FER]    = rx_ferr_i;
    stat_w[SB_PER]    = rx_perr_i;
    stat_w[SB_OER]    = rx_ovr_i;
    stat_w[SB_ERR]    = rx_brk_i | rx_ferr_i | rx_perr_i | rx_ovr_i;
    stat_w[SB_TOUT]   = fl_q[FL_TOUT];
    stat_w[SB_TX]     = fl_q[FL_TX];
    stat_w[SB_RX]     = fl_q[FL_RX];
    stat_w[SB_SUM]    = sum;
    stat_w[CNT_W-1:0] = rx_level_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = stat_w;
      ADDR_CHG:  rdata_o[NUM_CHG-1:0] = chg_q;
      default:   rdata_o = '0;
    endcase
  end

  p_ctrl_zero_masks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == '0) |-> !irq_o);
  p_tx_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fl_q[FL_RX] | fl_q[FL_TOUT]) == 1'b0 && chg_q == '0) |-> (irq_o == (fl_q[FL_TX] & ctrl_q[CB_TIE])));
  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (fl_q == '0 && chg_q == '0 && ctrl_q == '0));
endmodule

// File: tb/test_sio_irq_unit.sv
`timescale 1ns/1ps
module test_sio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_evt = 0, tx_evt = 0, to_evt = 0;
  logic [5:0]  chg_evt = '0;
  logic        brk = 0, empty = 0, fer = 0, per = 0, ovr = 0;
  logic [4:0]  level = '0;
  logic        irq;

  int unsigned n_chk = 0, n_fail = 0;
  logic [15:0] m_ctrl = '0;
  logic [2:0]  m_fl = '0;   // {timeout, tx, rx}
  logic [5:0]  m_chg = '0;

  always #2.5 clk = ~clk;

  sio_irq_unit i_sio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_data_evt_i(rx_evt), .tx_data_evt_i(tx_evt),
    .rx_tout_evt_i(to_evt), .chg_evt_i(chg_evt), .rx_brk_i(brk), .rx_empty_i(empty),
    .rx_ferr_i(fer), .rx_perr_i(per), .rx_ovr_i(ovr), .rx_level_i(level), .irq_o(irq)
  );

  function automatic logic m_sum();
    return |(m_chg & m_ctrl[5:0]);
  endfunction

  function automatic logic [15:0] exp_stat();
    return {brk, empty, fer, per, ovr, brk | fer | per | ovr,
            m_fl[2], m_fl[1], m_fl[0], m_sum(), 1'b0, level};
  endfunction

  function automatic logic exp_irq();
    return ((m_fl[0] | m_fl[2]) & m_ctrl[12]) | (m_fl[1] & m_ctrl[13]) | (m_sum() & m_ctrl[11]);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    addr = 2'd0; #0.3; chk({tag, " R2 ctrl"}, rdata, m_ctrl);
    addr = 2'd1; #0.3; chk({tag, " R3/R4/R5/R8 status"}, rdata, exp_stat());
    addr = 2'd2; #0.3; chk({tag, " R7 change"}, rdata, {10'd0, m_chg});
    addr = 2'd3; #0.3; chk({tag, " R2 unused addr"}, rdata, 16'h0);
    chk({tag, " R9 irq"}, {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  // advance one clock, updating the model from the driven inputs
  task automatic tick();
    if (wr_en && addr == 2'd0) m_ctrl = wdata & 16'hF83F;
    m_fl = (m_fl & ~((wr_en && addr == 2'd1) ? ~wdata[9:7] : 3'b000)) | {to_evt, tx_evt, rx_evt};
    m_chg = (m_chg & ~((wr_en && addr == 2'd2) ? ~wdata[5:0] : 6'd0)) | chg_evt;
    @(posedge clk); #0.5;
    wr_en = 0; rx_evt = 0; tx_evt = 0; to_evt = 0; chg_evt = '0;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1; tick();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");

    // R4 set and hold
    rx_evt = 1; tx_evt = 1; to_evt = 1; tick(); tick();
    check_all("R4");
    // R5 write 1 keeps, write 0 clears only that flag
    wr(2'd1, 16'hFEFF);  // clear tx only
    check_all("R5");
    chk("R5 tx cleared rx kept", {13'd0, m_fl}, 16'h0005);
    // R6 collision: rx set while cleared
    rx_evt = 1; wr(2'd1, 16'h0000);
    check_all("R6");
    addr = 2'd1; #0.3; chk("R6 rx survives collision", {15'd0, rdata[7]}, 16'h0001);
    // R10 tx flag with tx enable clear
    wr(2'd1, 16'h0000);
    tx_evt = 1; tick();
    wr(2'd0, 16'h1000);  // receive enable only
    addr = 2'd1; #0.3; chk("R10 tx flag visible", {15'd0, rdata[8]}, 16'h0001);
    chk("R10 no irq", {15'd0, irq}, 16'h0);
    wr(2'd0, 16'h2000);
    chk("R10 irq with enable", {15'd0, irq}, 16'h0001);
    // R8 summary per-source enable
    chg_evt = 6'b000100; tick();
    wr(2'd0, 16'h0800 | 16'h0008);
    addr = 2'd1; #0.3; chk("R8 mismatched enable", {15'd0, rdata[6]}, 16'h0);
    wr(2'd0, 16'h0800 | 16'h0004);
    addr = 2'd1; #0.3; chk("R8 matched enable", {15'd0, rdata[6]}, 16'h0001);
    check_all("R8");
    // R11 all flags set, control zero
    rx_evt = 1; tx_evt = 1; to_evt = 1; chg_evt = 6'h3F; tick();
    wr(2'd0, 16'h0000);
    chk("R11 masked", {15'd0, irq}, 16'h0);
    wr(2'd0, 16'hFFFF);
    check_all("R2 full write");
    // R3 level inputs
    brk = 1; ovr = 1; level = 5'd17; #0.3;
    check_all("R3");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      check_all("rand");
      rx_evt  = ($urandom % 4) == 0;
      tx_evt  = ($urandom % 4) == 0;
      to_evt  = ($urandom % 6) == 0;
      chg_evt = 6'($urandom) & 6'($urandom);
      {brk, empty, fer, per, ovr} = 5'($urandom);
      level = 5'($urandom);
      addr  = 2'($urandom);
      wdata = 16'($urandom) | 16'($urandom);
      if (addr == 2'd0) wdata = 16'($urandom);
      wr_en = ($urandom % 3) == 0;
      tick();
    end
    check_all("final");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule